// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level translation table held in ordinary memory. A first-level (directory) entry either points at a second-level table of 4 KB page entries or, when large pages are enabled and its size bit is set, maps a 4 MB page directly. The walker combines the user and writable rights of both levels. It checks the request against them, keeping in mind the write-protect control for supervisor writes. It marks the entries it used as accessed, marks the final entry dirty on a write, and writes an entry back only when one of its bits actually changed.

A client presents one request at a time (address, write, user) together with the paging controls, the table base and an address-line-20 mask. The walker issues single-word reads and writes on a request/acknowledge memory port. It finishes with a one-cycle done pulse. The result is then held until the next request completes: either a physical address with its granted rights, or a page fault with a three-bit error code.

Top module: `pgwalk_top`

## Requirements
- R1: With `pg_en` low, a request completes with `phys_addr` equal to `req_addr`, `grant_wr` and `grant_usr` high, no fault, and no memory transaction.
- R2: The directory entry is read from byte address ((`tbl_base` with bits 11:0 cleared) + 4 × linear bits 31:22) AND `a20_mask`; every memory address the block issues is word aligned and has no bit set that the request's A20 mask clears.
- R3: Entry bit 0 is the present bit; a directory or table entry with bit 0 clear ends the walk with `fault` high and error code bit 0 clear.
- R4: Entry bit 7 is the size bit; a directory entry with bit 7 set while `lp_en` is high maps a 4 MB page, giving physical address {entry bits 31:22, linear bits 21:0}. With `lp_en` low the same entry is used as a pointer to a second-level table.
- R5: For a 4 KB page the table entry is read from ((directory entry with bits 11:0 cleared) + 4 × linear bits 21:12) AND `a20_mask`, and the physical address is {table entry bits 31:12, linear bits 11:0}.
- R6: Entry bit 2 is user and bit 1 is writable; the effective rights are the AND of both levels (the directory alone for a 4 MB page). A user access without user right faults, a user write without writable right faults, and a supervisor write without writable right faults only while `wp_en` is high. On success `grant_usr` is the effective user right and `grant_wr` is the effective writable right OR (supervisor access AND `wp_en` low).
- R7: Entry bit 5 (accessed) is set in every entry the walk uses; bit 6 (dirty) is also set in the final entry on a write; an entry is written back only if its value changed.
- R8: The fault error code is {user access, write access, protection violation} in bits 2, 1, 0.
- R9: The physical address of a translated request is ANDed with `a20_mask`.
- R10: A protection fault writes back no entry at the faulting level; only accessed bits of levels already passed may have been written.
- R11: `mem_req` stays high with a stable address, write flag and data until `mem_ack`; `req_valid` is ignored while `busy`; `done` is a one-cycle pulse and the results hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| pg_en | input | 1 | Paging enabled |
| wp_en | input | 1 | Write protection applies to supervisor writes |
| lp_en | input | 1 | Large (4 MB) pages enabled |
| tbl_base | input | 32 | Directory base address |
| a20_mask | input | 32 | Mask applied to all physical addresses |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transaction accepted/completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | A translation is in progress |
| done | output | 1 | One-cycle completion pulse |
| phys_addr | output | 32 | Translated physical address |
| grant_wr | output | 1 | Write allowed on the translated page |
| grant_usr | output | 1 | User access allowed on the translated page |
| fault | output | 1 | Translation ended in a page fault |
| fault_code | output | 3 | {user, write, protection} |

## Verification
The bench targets entries whose accessed bit is already set (a walker that always writes back would show extra writes), a supervisor write to a read-only page with and without write protection (a wrong rule either faults legal writes or lets illegal ones through), and a size-bit directory entry with large pages off (a walker that ignores `lp_en` would return a 4 MB mapping instead of following the pointer). It also uses an A20 mask that changes a second-level table address and the final address (a missing mask reads the wrong table). It checks that a user fault found at the table level leaves that entry untouched while the directory's accessed bit is still written, and that a request pulsed mid-walk does not disturb the result.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  // entry bit positions (hardware table format)
  localparam int B_P  = 0;
  localparam int B_W  = 1;
  localparam int B_U  = 2;
  localparam int B_A  = 5;
  localparam int B_D  = 6;
  localparam int B_PS = 7;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DIR_RD = 3'd1,
    ST_DIR_WB = 3'd2,
    ST_TBL_RD = 3'd3,
    ST_TBL_WB = 3'd4,
    ST_FIN    = 3'd5
  } walk_st_t;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int AW    = 32,
  parameter int OFS_W = 12,
  parameter int IDX_W = 10
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] dir_ent,
  input  logic [AW-1:0] tbl_ent,
  input  logic [AW-1:0] a20,
  output logic [AW-1:0] dir_addr,
  output logic [AW-1:0] tbl_addr,
  output logic [AW-1:0] pa_small,
  output logic [AW-1:0] pa_large
);
  localparam int BIG_W = OFS_W + IDX_W;
  localparam logic [AW-1:0] FRAME_MASK = ~((AW'(1) << OFS_W) - AW'(1));
  localparam logic [AW-1:0] BIG_MASK   = ~((AW'(1) << BIG_W) - AW'(1));

  function automatic logic [AW-1:0] slot(input logic [IDX_W-1:0] idx);
    slot = '0;
    slot[IDX_W+1:2] = idx;
  endfunction

  function automatic logic [AW-1:0] join_pa(input logic [AW-1:0] frm, input logic [AW-1:0] lin,
                                            input logic [AW-1:0] msk);
    join_pa = (frm & msk) | (lin & ~msk);
  endfunction

  assign dir_addr = ((base & FRAME_MASK) + slot(va[AW-1 -: IDX_W])) & a20;
  assign tbl_addr = ((dir_ent & FRAME_MASK) + slot(va[BIG_W-1 -: IDX_W])) & a20;
  assign pa_small = join_pa(tbl_ent, va, FRAME_MASK) & a20;
  assign pa_large = join_pa(dir_ent, va, BIG_MASK) & a20;
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm #(
  parameter int EW = 32
) (
  input  logic [EW-1:0] dir_ent,
  input  logic [EW-1:0] tbl_ent,
  input  logic          big,
  input  logic          acc_wr,
  input  logic          acc_usr,
  input  logic          wp,
  output logic          eff_u,
  output logic          eff_w,
  output logic          viol,
  output logic          grant_w,
  output logic [EW-1:0] dir_new,
  output logic [EW-1:0] tbl_new
);
  import pgwalk_pkg::*;

  function automatic logic f_viol(input logic u, input logic w, input logic usr,
                                  input logic wr, input logic wpe);
    if (usr) f_viol = !u || (wr && !w);
    else     f_viol = wr && wpe && !w;
  endfunction

  function automatic logic [EW-1:0] f_mark(input logic [EW-1:0] e, input logic dirty);
    f_mark = e;
    f_mark[B_A] = 1'b1;
    if (dirty) f_mark[B_D] = 1'b1;
  endfunction

  assign eff_u   = big ? dir_ent[B_U] : (dir_ent[B_U] & tbl_ent[B_U]);
  assign eff_w   = big ? dir_ent[B_W] : (dir_ent[B_W] & tbl_ent[B_W]);
  assign viol    = f_viol(eff_u, eff_w, acc_usr, acc_wr, wp);
  assign grant_w = eff_w || (!acc_usr && !wp);
  assign dir_new = f_mark(dir_ent, big && acc_wr);
  assign tbl_new = f_mark(tbl_ent, acc_wr);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int AW    = 32,
  parameter int OFS_W = 12,
  parameter int IDX_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_user,
  input  logic          pg_en,
  input  logic          wp_en,
  input  logic          lp_en,
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] a20_mask,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] phys_addr,
  output logic          grant_wr,
  output logic          grant_usr,
  output logic          fault,
  output logic [2:0]    fault_code
);
  import pgwalk_pkg::*;

  walk_st_t      st;
  logic [AW-1:0] va_q, base_q, a20_q, pde_q, pte_q, pa_q;
  logic          wr_q, usr_q, wp_q, lp_q, large_q;
  logic          fault_q, gw_q, gu_q;
  logic [2:0]    code_q;

  // named internal events
  logic          xfer, ent_present, big_now, big_sel, dir_chg, tbl_chg;
  logic [AW-1:0] dir_ent, dir_addr, tbl_addr, pa_small, pa_large, dir_new, tbl_new;
  logic          eff_u, eff_w, viol, grant_w;

  assign xfer        = mem_req && mem_ack;
  assign ent_present = mem_rdata[B_P];
  assign big_now     = mem_rdata[B_PS] && lp_q;
  assign big_sel     = (st == ST_DIR_RD) && big_now;
  assign dir_ent     = (st == ST_DIR_RD) ? mem_rdata : pde_q;
  assign dir_chg     = dir_new != mem_rdata;
  assign tbl_chg     = tbl_new != mem_rdata;

  pgwalk_addr #(.AW(AW), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_addr (
    .base(base_q), .va(va_q), .dir_ent(dir_ent), .tbl_ent(mem_rdata), .a20(a20_q),
    .dir_addr(dir_addr), .tbl_addr(tbl_addr), .pa_small(pa_small), .pa_large(pa_large)
  );

  pgwalk_perm #(.EW(AW)) u_perm (
    .dir_ent(dir_ent), .tbl_ent(mem_rdata), .big(big_sel), .acc_wr(wr_q),
    .acc_usr(usr_q), .wp(wp_q), .eff_u(eff_u), .eff_w(eff_w), .viol(viol),
    .grant_w(grant_w), .dir_new(dir_new), .tbl_new(tbl_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      va_q <= '0; base_q <= '0; a20_q <= '0; pde_q <= '0; pte_q <= '0; pa_q <= '0;
      wr_q <= 1'b0; usr_q <= 1'b0; wp_q <= 1'b0; lp_q <= 1'b0; large_q <= 1'b0;
      fault_q <= 1'b0; gw_q <= 1'b0; gu_q <= 1'b0; code_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q <= req_addr; wr_q <= req_write; usr_q <= req_user;
          wp_q <= wp_en; lp_q <= lp_en; base_q <= tbl_base; a20_q <= a20_mask;
          fault_q <= 1'b0;
          code_q <= {req_user, req_write, 1'b0};
          if (!pg_en) begin
            pa_q <= req_addr; gw_q <= 1'b1; gu_q <= 1'b1;
            st <= ST_FIN;
          end else begin
            st <= ST_DIR_RD;
          end
        end
        ST_DIR_RD: if (xfer) begin
          pde_q   <= dir_new;
          large_q <= big_now;
          if (!ent_present) begin
            fault_q <= 1'b1; st <= ST_FIN;
          end else if (big_now) begin
            if (viol) begin
              fault_q <= 1'b1; code_q[0] <= 1'b1; st <= ST_FIN;
            end else begin
              pa_q <= pa_large; gw_q <= grant_w; gu_q <= eff_u;
              st <= dir_chg ? ST_DIR_WB : ST_FIN;
            end
          end else begin
            st <= dir_chg ? ST_DIR_WB : ST_TBL_RD;
          end
        end
        ST_DIR_WB: if (xfer) st <= large_q ? ST_FIN : ST_TBL_RD;
        ST_TBL_RD: if (xfer) begin
          pte_q <= tbl_new;
          if (!ent_present) begin
            fault_q <= 1'b1; st <= ST_FIN;
          end else if (viol) begin
            fault_q <= 1'b1; code_q[0] <= 1'b1; st <= ST_FIN;
          end else begin
            pa_q <= pa_small; gw_q <= grant_w; gu_q <= eff_u;
            st <= tbl_chg ? ST_TBL_WB : ST_FIN;
          end
        end
        ST_TBL_WB: if (xfer) st <= ST_FIN;
        ST_FIN:    st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req    = (st == ST_DIR_RD) || (st == ST_DIR_WB) || (st == ST_TBL_RD) || (st == ST_TBL_WB);
  assign mem_we     = (st == ST_DIR_WB) || (st == ST_TBL_WB);
  assign mem_addr   = ((st == ST_DIR_RD) || (st == ST_DIR_WB)) ? dir_addr : tbl_addr;
  assign mem_wdata  = (st == ST_DIR_WB) ? pde_q : pte_q;
  assign busy       = st != ST_IDLE;
  assign done       = st == ST_FIN;
  assign phys_addr  = pa_q;
  assign grant_wr   = gw_q;
  assign grant_usr  = gu_q;
  assign fault      = fault_q;
  assign fault_code = code_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic [AW-1:0] a20_q
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done);

  p_word_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  p_a20_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr & ~a20_q) == '0);

  p_wb_accessed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[5]);
endmodule

bind pgwalk_top pgwalk_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .a20_q(a20_q)
);

// File: tb/sim_pgwalk_top.sv
`timescale 1ns/1ps
module sim_pgwalk_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic pg_en = 1'b0, wp_en = 1'b0, lp_en = 1'b0;
  logic [31:0] req_addr = '0, tbl_base = 32'h0001_0000, a20_mask = 32'hFFFF_FFFF;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic busy, done, grant_wr, grant_usr, fault;
  logic [31:0] phys_addr;
  logic [2:0] fault_code;

  int checks = 0, failures = 0;
  int rd_total = 0, wr_total = 0, mem_lat = 0, wait_cnt = 0;
  bit [31:0] ram [bit [31:0]];
  bit [31:0] exp_w [bit [31:0]];

  always #2.5 clk = ~clk;

  pgwalk_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_user(req_user), .pg_en(pg_en), .wp_en(wp_en),
    .lp_en(lp_en), .tbl_base(tbl_base), .a20_mask(a20_mask), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .phys_addr(phys_addr),
    .grant_wr(grant_wr), .grant_usr(grant_usr), .fault(fault), .fault_code(fault_code)
  );

  function automatic bit [31:0] rdm(input bit [31:0] a);
    return ram.exists(a) ? ram[a] : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder; every write is compared on the clock it happens (R7, R10)
  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      wait_cnt = 0;
    end else if (mem_req) begin
      if (wait_cnt >= mem_lat) begin
        mem_ack <= 1'b1;
        mem_rdata <= rdm(mem_addr);
        if (mem_we) begin
          checks++;
          if (!exp_w.exists(mem_addr) || exp_w[mem_addr] != mem_wdata) begin
            failures++;
            $display("FAIL R10 unexpected write addr=%h actual=%h expected=%h", mem_addr, mem_wdata,
                     exp_w.exists(mem_addr) ? exp_w[mem_addr] : 32'h0);
          end
          ram[mem_addr] = mem_wdata;
          wr_total++;
        end else begin
          rd_total++;
        end
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic run(input string tag, input logic [31:0] va, input bit wr, input bit usr,
                     input bit pg, input bit wp, input bit lp, input logic [31:0] a20,
                     input int lat, input bit poke);
    bit [31:0] pdea, ptea, pde, pte, e_pa, npde, npte;
    bit e_flt, e_gw, e_gu, u, w, bad, big;
    bit [2:0] e_code;
    int e_rd, rd0, wr0, guard;
    exp_w.delete();
    e_flt = 0; e_gw = 1; e_gu = 1; e_pa = va; e_rd = 0; e_code = {usr, wr, 1'b0};
    if (pg) begin
      pdea = ((tbl_base & 32'hFFFF_F000) + ((va >> 22) * 4)) & a20;
      pde = rdm(pdea); e_rd = 1;
      big = pde[7] && lp;
      if (!pde[0]) e_flt = 1;
      else if (big) begin
        u = pde[2]; w = pde[1];
        bad = usr ? (!u || (wr && !w)) : (wr && wp && !w);
        if (bad) begin e_flt = 1; e_code[0] = 1; end
        else begin
          npde = pde | 32'h20 | (wr ? 32'h40 : 32'h0);
          if (npde != pde) exp_w[pdea] = npde;
          e_pa = ((pde & 32'hFFC0_0000) | (va & 32'h003F_FFFF)) & a20;
          e_gu = u; e_gw = w || (!usr && !wp);
        end
      end else begin
        npde = pde | 32'h20;
        if (npde != pde) exp_w[pdea] = npde;
        ptea = ((pde & 32'hFFFF_F000) + (((va >> 12) & 32'h3FF) * 4)) & a20;
        pte = rdm(ptea); e_rd = 2;
        if (!pte[0]) e_flt = 1;
        else begin
          u = pde[2] && pte[2]; w = pde[1] && pte[1];
          bad = usr ? (!u || (wr && !w)) : (wr && wp && !w);
          if (bad) begin e_flt = 1; e_code[0] = 1; end
          else begin
            npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
            if (npte != pte) exp_w[ptea] = npte;
            e_pa = ((pte & 32'hFFFF_F000) | (va & 32'hFFF)) & a20;
            e_gu = u; e_gw = w || (!usr && !wp);
          end
        end
      end
    end
    rd0 = rd_total; wr0 = wr_total; mem_lat = lat;
    @(negedge clk);
    req_valid = 1; req_addr = va; req_write = wr; req_user = usr;
    pg_en = pg; wp_en = wp; lp_en = lp; a20_mask = a20;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin  // R11: request while busy must be ignored
      req_valid = 1; req_addr = ~va; req_write = !wr; req_user = !usr;
      @(negedge clk);
      req_valid = 0; req_addr = va;
    end
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    check({tag, " done seen"}, {31'b0, done}, 32'd1);
    check({tag, " fault"}, {31'b0, fault}, {31'b0, e_flt});
    if (e_flt) check({tag, " R8 fault_code"}, {29'b0, fault_code}, {29'b0, e_code});
    else begin
      check({tag, " R9 phys_addr"}, phys_addr, e_pa);
      check({tag, " R6 grants"}, {30'b0, grant_wr, grant_usr}, {30'b0, e_gw, e_gu});
    end
    @(negedge clk);
    check({tag, " R11 done pulse / hold"}, {31'b0, done}, 32'd0);
    if (!e_flt) check({tag, " R11 result held"}, phys_addr, e_pa);
    check({tag, " R7 write count"}, wr_total - wr0, exp_w.num());
    check({tag, " read count"}, rd_total - rd0, e_rd);
    foreach (exp_w[a]) check({tag, " R7 entry after walk"}, rdm(a), exp_w[a]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // directory at 0x10000, one table at 0x20000
    ram[32'h0001_0004] = 32'h0002_0007;  // dir 1: P W U, A clear
    ram[32'h0002_000C] = 32'h0ABC_D007;
    ram[32'h0002_0010] = 32'h0123_4007;
    ram[32'h0002_0018] = 32'h0555_5025;  // W clear
    ram[32'h0001_000C] = 32'h0002_0003;  // dir 3: no U, A clear
    ram[32'h0001_0010] = 32'h1FC0_00A7;  // dir 4: 4 MB page
    ram[32'h0001_0014] = 32'h0012_0027;  // dir 5: table at 0x120000 (bit 20)
    ram[32'h0002_001C] = 32'h0777_7025;

    repeat (3) @(negedge clk);
    check("R11 reset busy/done/req/fault", {28'b0, busy, done, mem_req, fault}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    run("R1 paging off",                32'h8765_4321, 1, 1, 0, 1, 1, 32'hFFFF_FFFF, 0, 0);
    run("R2 R5 R7 first 4KB read",      32'h0040_3123, 0, 0, 1, 0, 0, 32'hFFFF_FFFF, 1, 0);
    run("R7 user write sets dirty",     32'h0040_4456, 1, 1, 1, 1, 0, 32'hFFFF_FFFF, 2, 0);
    run("R7 repeat no writeback",       32'h0040_4456, 1, 1, 1, 1, 0, 32'hFFFF_FFFF, 0, 1);
    run("R3 dir not present",           32'h0080_0000, 0, 1, 1, 0, 0, 32'hFFFF_FFFF, 0, 0);
    run("R10 user no-U at table level", 32'h00C0_3123, 0, 1, 1, 0, 0, 32'hFFFF_FFFF, 3, 0);
    run("R3 table not present",         32'h00C0_5000, 1, 0, 1, 0, 0, 32'hFFFF_FFFF, 1, 0);
    run("R6 user write read-only",      32'h0040_6ABC, 1, 1, 1, 0, 0, 32'hFFFF_FFFF, 0, 0);
    run("R6 supervisor write wp off",   32'h0040_6ABC, 1, 0, 1, 0, 0, 32'hFFFF_FFFF, 1, 0);
    run("R6 supervisor write wp on",    32'h0040_6ABC, 1, 0, 1, 1, 0, 32'hFFFF_FFFF, 2, 0);
    run("R4 size bit with lp off",      32'h0123_4567, 0, 0, 1, 0, 0, 32'hFFFF_FFFF, 0, 0);
    run("R4 4MB read",                  32'h0123_4567, 0, 1, 1, 1, 1, 32'hFFFF_FFFF, 1, 0);
    run("R4 R7 4MB write dirty",        32'h0123_4567, 1, 1, 1, 1, 1, 32'hFFFF_FFFF, 0, 1);
    run("R9 a20 masks final address",   32'h0040_3123, 0, 0, 1, 0, 0, 32'hFFEF_FFFF, 0, 0);
    run("R5 table addr unmasked",       32'h0140_7000, 0, 0, 1, 0, 0, 32'hFFFF_FFFF, 0, 0);
    run("R2 R9 table addr masked",      32'h0140_7000, 0, 0, 1, 0, 0, 32'hFFEF_FFFF, 2, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule